// File: doc/BRIEF.md
# Asynchronous-to-Synchronous Character Converter

This block sits between a character-framed serial input and a transmitter that needs bits at one exact rate. The input line carries characters made of a low start bit, a run of data bits sent least significant first, and a high stop bit. The sender's rate may drift a little above or below nominal. The block samples the line with a 16x oversampling enable and confirms each start bit at its middle. It holds recovered characters in a small buffer and sends them again, one bit per pulse of an exact bit-rate strobe.

Rates are matched at character boundaries. When the buffer is full at the point where a stop bit would go out, that stop bit is dropped and the next start bit is sent in its place. When nothing is waiting, the output stays high for one more bit time. A character that stays low through its stop position is a break, and it is sent as a longer low run so that the far end sees it as a break. With bypass set, the line is sampled on each strobe and passed straight to the output.

Top module: `async_sync_conv`

## Requirements
- R1: While reset is held, and just after it is released, `txd_out` is high (mark) and `overflow` is low.
- R2: `char_len` values 0, 1, 2 and 3 select a character length N of 8, 9, 10 and 11 bits, counting start and stop. Each character received with a low start bit, N-2 data bits least significant first and a high stop bit is sent again in the same framing. `txd_out` changes only on clock edges where `bit_tick` is high.
- R3: A low pulse on `txd_in` that ends before the middle of a bit (8 oversampling enables) is rejected and produces no output character.
- R4: When no character is waiting at a bit boundary, `txd_out` is high for that bit time, so characters that arrive slowly are separated by extra stop bits.
- R5: If the buffer holds its full depth of characters when a stop bit is due, that stop bit is skipped and the next start bit follows the last data bit. Input about 6% faster than the output then loses no character and never sets `overflow`.
- R6: A character whose data bits and stop position are all low is a break. It is sent as exactly 2N+3 consecutive low bit times followed by a high bit. The receiver then waits for the line to go high before it looks for the next start bit.
- R7: A character that completes while the buffer already holds its full depth of characters is dropped and sets `overflow`. `overflow` stays high until reset.
- R8: With `bypass` high, `txd_out` equals the value `txd_in` had at the most recent clock edge where `bit_tick` was high.
- R9: The framing of R2 and the break length of R6 follow `char_len` in all four settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| os_tick | input | 1 | Enable at 16 times the nominal input bit rate |
| bit_tick | input | 1 | One-cycle strobe at the exact output bit rate |
| char_len | input | 2 | Character length select: N = 8 + char_len |
| bypass | input | 1 | 1: pass the input through, sampled on `bit_tick` |
| txd_in | input | 1 | Character-framed serial input, idle high |
| txd_out | output | 1 | Synchronous serial output |
| overflow | output | 1 | Sticky flag: a character was lost to a full buffer |

## Verification
The bench builds the block with its defaults: 16x oversampling and a two-character buffer. With `os_tick` at every second clock, one nominal input bit is 32 cycles, so short runs reach each character length. They also reach an exhaustive sweep of all 64 data values at the shortest length, and buffer fill within a few dozen characters once the input is run about 6% fast. A full buffer is a depth of only two, so the stop-deletion and overflow paths can be reached with a handful of characters when `bit_tick` is paused. The bench decodes the output stream itself and compares characters, break lengths, deleted stops and inserted marks against what it sent.

// File: rtl/async_sync_conv_pkg.sv
// Package: shared constants, buffer entry type and state encodings for
// the asynchronous-to-synchronous converter.
// Assumes the character length select is two bits wide (N = 8..11).
package async_sync_conv_pkg;

    localparam int LEN_W    = 2;                          // width of char_len
    localparam int MIN_DATA = 6;                          // data bits at N = 8
    localparam int MAX_DATA = MIN_DATA + (1 << LEN_W) - 1; // data bits at N = 11

    // One buffered character: data bits plus a break marker.
    typedef struct packed {
        logic                brk;
        logic [MAX_DATA-1:0] data;
    } char_entry_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_HOLD
    } rx_state_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_DATA,
        TX_STOP,
        TX_BRK
    } tx_state_t;

endpackage

// File: rtl/async_sync_conv_rx.sv
// Character sampler: synchronises the serial line and samples it on the
// oversampling enable. It detects a start bit on a low level, confirms it at
// mid-bit, then samples the data bits and the stop position at their centres.
// It pushes one entry per character and marks a break when the data and the
// stop position are all low. After a low stop position it waits for the line
// to return high.
// Assumes OS_RATE is a power of two and at least 4.
module async_sync_conv_rx
    import async_sync_conv_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        os_tick,
    input  logic        line_in,
    input  logic [3:0]  n_data,
    output logic        push,
    output char_entry_t push_entry
);

    localparam int OS_W = $clog2(OS_RATE);
    localparam logic [OS_W-1:0] HALF_CNT = OS_W'(OS_RATE / 2 - 1);
    localparam logic [OS_W-1:0] LAST_CNT = OS_W'(OS_RATE - 1);

    logic                meta_q;
    logic                line_s;
    rx_state_t           state;
    logic [OS_W-1:0]     os_cnt;
    logic [3:0]          bit_idx;
    logic [MAX_DATA-1:0] shift_data;
    logic [3:0]          last_idx;

    assign last_idx = n_data - 4'd1;

    // Two-stage synchroniser on the incoming line; resets to mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            line_s <= 1'b1;
        end else begin
            meta_q <= line_in;
            line_s <= meta_q;
        end
    end

    // Framing state machine: start check, data sampling, stop check, break hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= RX_IDLE;
            os_cnt     <= '0;
            bit_idx    <= '0;
            shift_data <= '0;
            push       <= 1'b0;
            push_entry <= '0;
        end else begin
            push <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (os_tick && !line_s) begin
                        os_cnt <= '0;
                        state  <= RX_START;
                    end
                end
                RX_START: begin
                    if (os_tick) begin
                        if (os_cnt == HALF_CNT) begin
                            os_cnt <= '0;
                            if (!line_s) begin
                                state      <= RX_DATA;
                                bit_idx    <= '0;
                                shift_data <= '0;
                            end else begin
                                state <= RX_IDLE;
                            end
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (os_tick) begin
                        if (os_cnt == LAST_CNT) begin
                            os_cnt              <= '0;
                            shift_data[bit_idx] <= line_s;
                            if (bit_idx == last_idx) begin
                                state <= RX_STOP;
                            end else begin
                                bit_idx <= bit_idx + 4'd1;
                            end
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                end
                RX_STOP: begin
                    if (os_tick) begin
                        if (os_cnt == LAST_CNT) begin
                            os_cnt          <= '0;
                            push            <= 1'b1;
                            push_entry.data <= shift_data;
                            push_entry.brk  <= !line_s && (shift_data == '0);
                            state           <= line_s ? RX_IDLE : RX_HOLD;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    if (line_s) begin
                        state <= RX_IDLE;
                    end
                end
            endcase
        end
    end

    // A character takes many oversampling periods, so pushes never come back to back.
    assert_single_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !push);

    // A break entry never carries data bits.
    assert_break_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && push_entry.brk) |-> (push_entry.data == '0));

endmodule

// File: rtl/async_sync_conv_buf.sv
// Holding buffer: a small circular store of character entries between the
// sampler and the serializer. A push arriving while it is full, with no pop
// in the same cycle, is dropped and sets a sticky overflow flag.
// Assumes the reader pops only when the buffer is not empty.
module async_sync_conv_buf
    import async_sync_conv_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  char_entry_t                wr_entry,
    input  logic                       pop,
    output char_entry_t                rd_entry,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       overflow
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    char_entry_t      mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             accept;

    assign accept   = push && ((level != CNT_FULL) || pop);
    assign rd_entry = mem[rd_ptr];

    // Storage write; no reset needed on the data itself.
    always_ff @(posedge clk) begin
        if (accept) begin
            mem[wr_ptr] <= wr_entry;
        end
    end

    // Pointer, fill level and sticky overflow bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            level    <= '0;
            overflow <= 1'b0;
        end else begin
            if (accept) begin
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            end
            if (accept && !pop) begin
                level <= level + 1'b1;
            end else if (pop && !accept) begin
                level <= level - 1'b1;
            end
            if (push && !accept) begin
                overflow <= 1'b1;
            end
        end
    end

    // The serializer must never read an empty buffer.
    assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (level != '0));

    // Once a character has been lost, the flag holds until reset.
    assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // The fill level never passes the depth.
    assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CNT_FULL);

endmodule

// File: rtl/async_sync_conv_tx.sv
// Serializer: on each bit strobe it emits one bit of the current character
// (start, data LSB first, stop) or a mark while idle. At a stop position with
// a full buffer and a normal character next, it skips the stop and starts
// that character at once. A break entry becomes a low run of brk_len bit
// times followed by a mark.
// Assumes n_data and brk_len do not change while a character is in flight.
module async_sync_conv_tx
    import async_sync_conv_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_tick,
    input  logic [3:0]  n_data,
    input  logic [4:0]  brk_len,
    input  logic        buf_full,
    input  logic        buf_empty,
    input  char_entry_t head,
    output logic        pop,
    output logic        txd_q
);

    tx_state_t           state;
    logic [3:0]          bit_idx;
    logic [MAX_DATA-1:0] shreg;
    logic [4:0]          brk_cnt;
    logic [3:0]          last_idx;
    logic                skip_stop;

    assign last_idx  = n_data - 4'd1;
    assign skip_stop = buf_full && !head.brk;

    // Take the next entry when idle with work waiting, or when a stop is skipped.
    always_comb begin
        pop = 1'b0;
        if (bit_tick) begin
            if (state == TX_IDLE && !buf_empty) begin
                pop = 1'b1;
            end else if (state == TX_STOP && skip_stop) begin
                pop = 1'b1;
            end
        end
    end

    // Bit sequencer: one output decision per bit strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= TX_IDLE;
            bit_idx <= '0;
            shreg   <= '0;
            brk_cnt <= '0;
            txd_q   <= 1'b1;
        end else if (bit_tick) begin
            case (state)
                TX_IDLE: begin
                    if (!buf_empty) begin
                        txd_q <= 1'b0;
                        if (head.brk) begin
                            state   <= TX_BRK;
                            brk_cnt <= 5'd1;
                        end else begin
                            state   <= TX_DATA;
                            shreg   <= head.data;
                            bit_idx <= '0;
                        end
                    end else begin
                        txd_q <= 1'b1;
                    end
                end
                TX_DATA: begin
                    txd_q <= shreg[bit_idx];
                    if (bit_idx == last_idx) begin
                        state <= TX_STOP;
                    end else begin
                        bit_idx <= bit_idx + 4'd1;
                    end
                end
                TX_STOP: begin
                    if (skip_stop) begin
                        txd_q   <= 1'b0;
                        state   <= TX_DATA;
                        shreg   <= head.data;
                        bit_idx <= '0;
                    end else begin
                        txd_q <= 1'b1;
                        state <= TX_IDLE;
                    end
                end
                default: begin
                    if (brk_cnt == brk_len) begin
                        txd_q <= 1'b1;
                        state <= TX_IDLE;
                    end else begin
                        txd_q   <= 1'b0;
                        brk_cnt <= brk_cnt + 5'd1;
                    end
                end
            endcase
        end
    end

    // The output moves only on bit strobes.
    assert_txd_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(txd_q));

    // A break run never counts past its programmed length.
    assert_brk_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_BRK) |-> (brk_cnt <= brk_len));

endmodule

// File: rtl/async_sync_conv.sv
// Top: asynchronous-to-synchronous character converter. It chains the
// sampler, the holding buffer and the serializer, derives the data-bit count
// and break length from char_len, and provides a bypass path that samples
// the line on each bit strobe.
// Assumes os_tick runs at OS_RATE times the nominal input bit rate and
// bit_tick is a one-cycle strobe at the exact output bit rate.
module async_sync_conv
    import async_sync_conv_pkg::*;
#(
    parameter int OS_RATE   = 16,
    parameter int BUF_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             os_tick,
    input  logic             bit_tick,
    input  logic [LEN_W-1:0] char_len,
    input  logic             bypass,
    input  logic             txd_in,
    output logic             txd_out,
    output logic             overflow
);

    localparam int CNT_W = $clog2(BUF_DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BUF_DEPTH);

    logic [3:0]       n_data;
    logic [4:0]       brk_len;
    logic             rx_push;
    char_entry_t      rx_entry;
    logic             tx_pop;
    char_entry_t      head;
    logic [CNT_W-1:0] level;
    logic             tx_txd;
    logic             byp_q;

    assign n_data  = 4'(MIN_DATA) + {2'b00, char_len};
    assign brk_len = 5'd19 + {2'b00, char_len, 1'b0};

    async_sync_conv_rx #(.OS_RATE(OS_RATE)) rx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .os_tick    (os_tick),
        .line_in    (txd_in),
        .n_data     (n_data),
        .push       (rx_push),
        .push_entry (rx_entry)
    );

    async_sync_conv_buf #(.DEPTH(BUF_DEPTH)) buf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (rx_push),
        .wr_entry (rx_entry),
        .pop      (tx_pop),
        .rd_entry (head),
        .level    (level),
        .overflow (overflow)
    );

    async_sync_conv_tx tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .n_data    (n_data),
        .brk_len   (brk_len),
        .buf_full  (level == CNT_FULL),
        .buf_empty (level == '0),
        .head      (head),
        .pop       (tx_pop),
        .txd_q     (tx_txd)
    );

    // Bypass sampler: capture the raw line on each bit strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byp_q <= 1'b1;
        end else if (bit_tick) begin
            byp_q <= txd_in;
        end
    end

    assign txd_out = bypass ? byp_q : tx_txd;

    // Reset leaves no pending loss flag.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> !overflow);

    // In bypass the output follows the line value taken at the strobe.
    assert_bypass_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && bit_tick) |=> (!bypass || (txd_out == $past(txd_in))));

endmodule

// File: tb/async_sync_conv_tb_top.sv
// Bench: drives framed characters at chosen bit periods, decodes the output
// stream bit by bit on every strobe and compares with what was sent.
module async_sync_conv_tb_top;

    logic       clk      = 1'b0;
    logic       rst_n    = 1'b0;
    logic       os_tick  = 1'b0;
    logic       bit_tick = 1'b0;
    logic [1:0] char_len = 2'd0;
    logic       bypass   = 1'b0;
    logic       txd_in   = 1'b1;
    logic       txd_out;
    logic       overflow;

    int bt_period = 32;
    int in_period = 32;
    int checks    = 0;
    int errors    = 0;

    int snt_val [512];
    int rcv_val [512];
    int rcv_run [512];
    int snt_cnt = 0;
    int rcv_cnt = 0;

    int dec_st = 0;
    int dec_i = 0;
    int dec_data = 0;
    int dec_run = 0;
    int deletions = 0;
    int marks_between = 0;
    int zeros_seen = 0;

    always #10 clk = ~clk;

    async_sync_conv dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .os_tick  (os_tick),
        .bit_tick (bit_tick),
        .char_len (char_len),
        .bypass   (bypass),
        .txd_in   (txd_in),
        .txd_out  (txd_out),
        .overflow (overflow)
    );

    function automatic int nd();
        return 6 + int'(char_len);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic record(input int v, input int run);
        if (rcv_cnt < 512) begin
            rcv_val[rcv_cnt] = v;
            rcv_run[rcv_cnt] = run;
        end
        rcv_cnt++;
    endtask

    // Output decoder: one call per output bit.
    task automatic decode_bit(input logic b);
        if (!b) zeros_seen++;
        case (dec_st)
            0: begin
                if (!b) begin
                    dec_st = 1; dec_i = 0; dec_data = 0;
                end else if (rcv_cnt > 0 && rcv_cnt < snt_cnt) begin
                    marks_between++;
                end
            end
            1: begin
                if (dec_i < nd()) begin
                    if (b) dec_data = dec_data | (1 << dec_i);
                    dec_i++;
                end else if (b) begin
                    record(dec_data, 0);
                    dec_st = 0;
                end else if (dec_data == 0) begin
                    dec_st = 2;
                    dec_run = nd() + 2;
                end else begin
                    record(dec_data, 0);
                    deletions++;
                    dec_i = 0; dec_data = 0;
                end
            end
            default: begin
                if (!b) dec_run++;
                else begin
                    record(-1, dec_run);
                    dec_st = 0;
                end
            end
        endcase
    endtask

    // Enable generator and output sampler, all at the falling edge.
    initial begin : tick_gen
        int bt_ph;
        bt_ph = 0;
        forever begin
            @(negedge clk);
            if (bit_tick && !bypass) decode_bit(txd_out);
            os_tick = !os_tick;
            if (bt_period > 0) begin
                bit_tick = (bt_ph >= bt_period - 1);
                bt_ph    = (bt_ph >= bt_period - 1) ? 0 : bt_ph + 1;
            end else begin
                bit_tick = 1'b0;
                bt_ph    = 0;
            end
        end
    end

    task automatic drive_bit(input logic b);
        @(negedge clk);
        txd_in = b;
        repeat (in_period - 1) @(negedge clk);
    endtask

    task automatic send_char(input int v);
        snt_val[snt_cnt] = v;
        snt_cnt++;
        drive_bit(1'b0);
        for (int i = 0; i < nd(); i++) drive_bit(logic'((v >> i) & 1));
        drive_bit(1'b1);
    endtask

    task automatic send_break();
        snt_val[snt_cnt] = -1;
        snt_cnt++;
        for (int i = 0; i < nd() + 4; i++) drive_bit(1'b0);
        drive_bit(1'b1);
        drive_bit(1'b1);
    endtask

    task automatic wait_bits(input int k);
        repeat (k * 34) @(negedge clk);
    endtask

    task automatic clear_group();
        snt_cnt = 0; rcv_cnt = 0;
    endtask

    task automatic compare_group(input string req);
        int lim;
        chk(rcv_cnt == snt_cnt, req, rcv_cnt, snt_cnt);
        lim = (rcv_cnt < snt_cnt) ? rcv_cnt : snt_cnt;
        for (int i = 0; i < lim; i++) begin
            chk(rcv_val[i] == snt_val[i], req, rcv_val[i], snt_val[i]);
            if (snt_val[i] == -1)
                chk(rcv_run[i] == 2 * (nd() + 2) + 3, "R6 break length",
                    rcv_run[i], 2 * (nd() + 2) + 3);
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R2 watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int mask;
        int z0;
        int c0;
        logic pat;
        repeat (5) @(negedge clk);
        chk(txd_out == 1'b1, "R1 reset mark", int'(txd_out), 1);
        chk(overflow == 1'b0, "R1 reset overflow", int'(overflow), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd_out == 1'b1, "R1 after release", int'(txd_out), 1);
        wait_bits(4);

        // R2 / R9: framing across every length, exhaustive at N = 8.
        for (int cl = 0; cl < 4; cl++) begin
            char_len = 2'(cl);
            mask = (1 << nd()) - 1;
            clear_group();
            if (cl == 0) begin
                for (int v = 0; v < 64; v++) begin
                    send_char(v);
                    drive_bit(1'b1);
                end
            end else begin
                send_char(0);
                send_char(mask);
                for (int k = 0; k < 16; k++) begin
                    send_char((k * 37 + cl * 11) & mask);
                    drive_bit(1'b1);
                end
            end
            wait_bits(40);
            compare_group(cl == 0 ? "R2 framing" : "R9 length sweep");
        end

        // R6 / R9: break stretching at every length, then a normal character.
        for (int cl = 0; cl < 4; cl++) begin
            char_len = 2'(cl);
            mask = (1 << nd()) - 1;
            clear_group();
            send_char(8'h15 & mask);
            send_break();
            send_char(mask);
            wait_bits(60);
            compare_group("R6 break");
        end

        // R3: short low glitch is rejected.
        char_len = 2'd0;
        z0 = zeros_seen;
        c0 = rcv_cnt;
        @(negedge clk);
        txd_in = 1'b0;
        repeat (6) @(negedge clk);
        txd_in = 1'b1;
        wait_bits(30);
        chk(zeros_seen == z0, "R3 glitch low bits", zeros_seen, z0);
        chk(rcv_cnt == c0, "R3 glitch characters", rcv_cnt, c0);
        chk(txd_out == 1'b1, "R3 glitch mark", int'(txd_out), 1);

        // R5: fast input, stop bits deleted, nothing lost.
        in_period = 31;
        bt_period = 33;
        clear_group();
        deletions = 0;
        for (int k = 0; k < 60; k++) send_char(((k * 5) % 63) + 1);
        wait_bits(40);
        compare_group("R5 fast input");
        chk(deletions > 0, "R5 stop deleted", deletions, 1);
        chk(overflow == 1'b0, "R5 no overflow", int'(overflow), 0);

        // R4: slow input, extra marks inserted.
        in_period = 33;
        bt_period = 32;
        wait_bits(4);
        clear_group();
        marks_between = 0;
        for (int k = 0; k < 20; k++) send_char(((k * 7) % 63) + 1);
        wait_bits(40);
        compare_group("R4 slow input");
        chk(marks_between > 0, "R4 marks inserted", marks_between, 1);

        // R7: overflow with strobes paused.
        in_period = 32;
        bt_period = 0;
        wait_bits(2);
        clear_group();
        send_char(5);
        send_char(9);
        wait_bits(2);
        chk(overflow == 1'b0, "R7 full but no loss", int'(overflow), 0);
        send_char(17);
        wait_bits(2);
        chk(overflow == 1'b1, "R7 overflow set", int'(overflow), 1);
        wait_bits(10);
        chk(overflow == 1'b1, "R7 overflow sticky", int'(overflow), 1);
        chk(txd_out == 1'b1, "R4 idle without strobes", int'(txd_out), 1);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(overflow == 1'b0, "R1 reset clears overflow", int'(overflow), 0);
        chk(txd_out == 1'b1, "R1 reset mark again", int'(txd_out), 1);
        rst_n = 1'b1;
        bt_period = 32;
        wait_bits(4);

        // R8: bypass follows the line at each strobe.
        bypass = 1'b1;
        for (int i = 0; i < 40; i++) begin
            pat = logic'(((i * 13) >> 2) & 1) ^ logic'(i & 1);
            @(negedge clk);
            txd_in = pat;
            do @(posedge clk); while (!bit_tick);
            @(negedge clk);
            chk(txd_out == pat, "R8 bypass", int'(txd_out), int'(pat));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule